// File: doc/BRIEF.md
# DRAM Supercell Access Controller

This block models a small dynamic memory chip whose storage is a grid of byte-wide supercells, together with the sequencer that reaches into it. A flat request address is split into a row number and a column number. Each access runs the same three-phase cycle. First, a row strobe opens the selected row and copies it into an internal row buffer. Sensing is destructive, so the array row is left cleared. Second, a column strobe either drives the addressed byte of the buffer to the read-data output or overwrites that byte with the write data. Third, the whole buffer is restored into the same array row.

A client presents a request while the block is idle. It watches `busy`, and it takes `done` as the one-cycle sign that the row has been restored. The row and column numbers appear in turn on one narrow multiplexed address output, together with the two strobes. This lets the phase sequence be observed the way it would be on a real chip's pins. The grid dimensions are parameters and must be powers of two, so the row is the upper address bits and the column is the lower bits.

States: `ST_IDLE`, `ST_ROW` (row strobe, sense into buffer), `ST_COL` (column strobe, byte read or update), `ST_RESTORE` (buffer written back). The transitions are as follows. IDLE moves to ROW on an accepted request. ROW always moves to COL. COL always moves to RESTORE. RESTORE always moves back to IDLE. With no request, IDLE stays in IDLE.

Top module: `dram_cell_ctrl`

## Requirements
- R1: After reset, `busy`, `done`, `row_strobe` and `col_strobe` are low, `rd_data` is 0, and every supercell reads back as 0.
- R2: Address bits [AW-1:CB] select the row and bits [CB-1:0] select the column (row = addr / COLS, column = addr mod COLS). In the default 4x4 grid, address 9 reaches row 2, column 1.
- R3: A request with `req_valid` high at a clock edge where `busy` is low is accepted. `busy` is then high for exactly three cycles (ST_ROW, ST_COL, ST_RESTORE in that order) and low again in the fourth.
- R4: In the first busy cycle, `row_strobe` is high, `col_strobe` is low, and `mem_addr` carries the row number.
- R5: In the second busy cycle, `col_strobe` is high, `row_strobe` is low, and `mem_addr` carries the column number.
- R6: In the third busy cycle both strobes are low and `mem_addr` carries the row number again. In the cycle after it, `done` is high for exactly one cycle with `busy` low.
- R7: A read updates `rd_data` with the addressed byte at the end of the column cycle, so it is visible from the restore cycle onward. It holds that value until the next read.
- R8: A write replaces only the addressed byte of the row and leaves `rd_data` unchanged. A later read of that address returns the written byte, and the other bytes of the same row keep their values.
- R9: Because every access restores its row, reading one address repeatedly keeps returning the same stored byte.
- R10: `req_valid` and the request fields are ignored while `busy` is high. Such a request neither starts an access nor alters any stored byte.
- R11: While idle, `mem_addr` is 0 and both strobes are low.
- R12: A request presented in the `done` cycle is accepted, so accesses can run back to back every four cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_addr | input | AW | Flat supercell address |
| req_we | input | 1 | 1 = write, 0 = read |
| req_wdata | input | W | Byte to store on a write |
| busy | output | 1 | Access in progress |
| done | output | 1 | One-cycle pulse after the row restore |
| rd_data | output | W | Byte returned by the last read |
| row_strobe | output | 1 | Row phase indicator |
| col_strobe | output | 1 | Column phase indicator |
| mem_addr | output | MW | Multiplexed row/column number |

## Verification
An access accepted at edge k shows `row_strobe` in the cycle after edge k and `col_strobe` after edge k+1. Read data and the restore phase appear after edge k+2, and `done` appears after edge k+3. The reference model in the bench advances a phase counter on the same edges. It compares every output at the falling edge, half a cycle after each change. Transaction-level checks sample `rd_data` in the `done` cycle, and the reads that follow show whether the written and ignored bytes ended up where they should.

// File: rtl/dsc_pkg.sv
package dsc_pkg;
    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_ROW     = 2'd1,
        ST_COL     = 2'd2,
        ST_RESTORE = 2'd3
    } dsc_state_e;
endpackage

// File: rtl/dsc_fsm.sv
module dsc_fsm
    import dsc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       req_valid,
    output dsc_state_e state_o,
    output logic       accept_o,
    output logic       busy_o,
    output logic       ras_o,
    output logic       cas_o,
    output logic       done_o
);
    dsc_state_e state_q, state_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (req_valid) state_d = ST_ROW;
            ST_ROW:     state_d = ST_COL;
            ST_COL:     state_d = ST_RESTORE;
            ST_RESTORE: state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        accept_o = 1'b0;
        busy_o   = 1'b1;
        ras_o    = 1'b0;
        cas_o    = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                busy_o   = 1'b0;
                accept_o = req_valid;
            end
            ST_ROW:     ras_o = 1'b1;
            ST_COL:     cas_o = 1'b1;
            ST_RESTORE: ;
            default:    busy_o = 1'b0;
        endcase
    end

    // completion pulse follows the restore phase
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) done_o <= 1'b0;
        else        done_o <= (state_q == ST_RESTORE);
    end

    assign state_o = state_q;
endmodule

// File: rtl/dsc_addr_mux.sv
module dsc_addr_mux
    import dsc_pkg::*;
#(
    parameter int RB = 2,
    parameter int CB = 2,
    parameter int MW = 2
) (
    input  dsc_state_e    state_i,
    input  logic [RB-1:0] row_i,
    input  logic [CB-1:0] col_i,
    output logic [MW-1:0] bus_o
);
    logic [MW-1:0] row_w, col_w;

    assign row_w = MW'(row_i);
    assign col_w = MW'(col_i);

    always_comb begin
        unique case (state_i)
            ST_ROW, ST_RESTORE: bus_o = row_w;
            ST_COL:             bus_o = col_w;
            default:            bus_o = '0;
        endcase
    end
endmodule

// File: rtl/dsc_array.sv
module dsc_array #(
    parameter int ROWS = 4,
    parameter int COLS = 4,
    parameter int W    = 8,
    localparam int RB  = $clog2(ROWS),
    localparam int LW  = COLS * W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sense_i,
    input  logic          restore_i,
    input  logic [RB-1:0] row_i,
    input  logic [LW-1:0] restore_data_i,
    output logic [LW-1:0] sense_data_o
);
    logic [LW-1:0] cells [ROWS];

    assign sense_data_o = cells[row_i];

    // sensing drains the row; restoring refills it
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int r = 0; r < ROWS; r++) cells[r] <= '0;
        end else if (sense_i) begin
            cells[row_i] <= '0;
        end else if (restore_i) begin
            cells[row_i] <= restore_data_i;
        end
    end
endmodule

// File: rtl/dsc_rowbuf.sv
module dsc_rowbuf #(
    parameter int COLS = 4,
    parameter int W    = 8,
    localparam int CB  = $clog2(COLS),
    localparam int LW  = COLS * W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_i,
    input  logic [LW-1:0] load_data_i,
    input  logic          upd_i,
    input  logic [CB-1:0] col_i,
    input  logic [W-1:0]  wdata_i,
    output logic [LW-1:0] line_o,
    output logic [W-1:0]  byte_o
);
    logic [W-1:0] slot_q [COLS];

    for (genvar c = 0; c < COLS; c++) begin : g_slot
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                slot_q[c] <= '0;
            else if (load_i)
                slot_q[c] <= load_data_i[c*W +: W];
            else if (upd_i && (col_i == CB'(c)))
                slot_q[c] <= wdata_i;
        end
        assign line_o[c*W +: W] = slot_q[c];
    end

    assign byte_o = slot_q[col_i];
endmodule

// File: rtl/dram_cell_ctrl.sv
module dram_cell_ctrl
    import dsc_pkg::*;
#(
    parameter int ROWS = 4,
    parameter int COLS = 4,
    parameter int W    = 8,
    localparam int RB  = $clog2(ROWS),
    localparam int CB  = $clog2(COLS),
    localparam int AW  = RB + CB,
    localparam int MW  = (RB > CB) ? RB : CB,
    localparam int LW  = COLS * W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic [AW-1:0] req_addr,
    input  logic          req_we,
    input  logic [W-1:0]  req_wdata,
    output logic          busy,
    output logic          done,
    output logic [W-1:0]  rd_data,
    output logic          row_strobe,
    output logic          col_strobe,
    output logic [MW-1:0] mem_addr
);
    dsc_state_e    state;
    logic          accept;
    logic [AW-1:0] addr_q;
    logic          we_q;
    logic [W-1:0]  wdata_q;
    logic [RB-1:0] row_sel;
    logic [CB-1:0] col_sel;
    logic [LW-1:0] sense_line, buf_line;
    logic [W-1:0]  buf_byte;

    dsc_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .state_o   (state),
        .accept_o  (accept),
        .busy_o    (busy),
        .ras_o     (row_strobe),
        .cas_o     (col_strobe),
        .done_o    (done)
    );

    // request capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q  <= '0;
            we_q    <= 1'b0;
            wdata_q <= '0;
        end else if (accept) begin
            addr_q  <= req_addr;
            we_q    <= req_we;
            wdata_q <= req_wdata;
        end
    end

    assign row_sel = addr_q[AW-1:CB];
    assign col_sel = addr_q[CB-1:0];

    dsc_addr_mux #(.RB(RB), .CB(CB), .MW(MW)) u_mux (
        .state_i (state),
        .row_i   (row_sel),
        .col_i   (col_sel),
        .bus_o   (mem_addr)
    );

    dsc_array #(.ROWS(ROWS), .COLS(COLS), .W(W)) u_array (
        .clk            (clk),
        .rst_n          (rst_n),
        .sense_i        (state == ST_ROW),
        .restore_i      (state == ST_RESTORE),
        .row_i          (row_sel),
        .restore_data_i (buf_line),
        .sense_data_o   (sense_line)
    );

    dsc_rowbuf #(.COLS(COLS), .W(W)) u_rowbuf (
        .clk         (clk),
        .rst_n       (rst_n),
        .load_i      (state == ST_ROW),
        .load_data_i (sense_line),
        .upd_i       ((state == ST_COL) && we_q),
        .col_i       (col_sel),
        .wdata_i     (wdata_q),
        .line_o      (buf_line),
        .byte_o      (buf_byte)
    );

    // read data register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            rd_data <= '0;
        else if ((state == ST_COL) && !we_q)
            rd_data <= buf_byte;
    end
endmodule

// File: rtl/dsc_checker.sv
module dsc_checker #(
    parameter int MW = 2,
    parameter int W  = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          req_valid,
    input logic          busy,
    input logic          done,
    input logic          row_strobe,
    input logic          col_strobe,
    input logic [MW-1:0] mem_addr,
    input logic [W-1:0]  rd_data
);
    assert_accept_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && req_valid) |=> (busy && row_strobe));

    assert_row_then_col_R5: assert property (@(posedge clk) disable iff (!rst_n)
        row_strobe |=> (col_strobe && busy));

    assert_col_then_restore_R6: assert property (@(posedge clk) disable iff (!rst_n)
        col_strobe |=> (busy && !row_strobe && !col_strobe));

    assert_restore_then_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !row_strobe && !col_strobe) |=> (done && !busy));

    assert_done_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_phase_exclusive_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({row_strobe, col_strobe, done}));

    assert_idle_bus_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (mem_addr == '0 && !row_strobe && !col_strobe));

    assert_rd_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(rd_data) |-> $past(col_strobe));
endmodule

bind dram_cell_ctrl dsc_checker #(.MW(MW), .W(W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .busy       (busy),
    .done       (done),
    .row_strobe (row_strobe),
    .col_strobe (col_strobe),
    .mem_addr   (mem_addr),
    .rd_data    (rd_data)
);

// File: tb/sim_dram_cell_ctrl.sv
`timescale 1ns/1ps
module sim_dram_cell_ctrl;
    localparam int ROWS = 4, COLS = 4, W = 8;
    localparam int CB = 2, AW = 4, MW = 2, N = ROWS * COLS;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic req_we = 1'b0;
    logic [W-1:0] req_wdata = '0;
    logic busy, done, row_strobe, col_strobe;
    logic [W-1:0] rd_data;
    logic [MW-1:0] mem_addr;

    int vectors = 0;
    int fails = 0;
    int cyc = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    dram_cell_ctrl #(.ROWS(ROWS), .COLS(COLS), .W(W)) u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .req_we(req_we), .req_wdata(req_wdata), .busy(busy), .done(done),
        .rd_data(rd_data), .row_strobe(row_strobe), .col_strobe(col_strobe),
        .mem_addr(mem_addr)
    );

    // behavioural reference
    int       m_phase = 0;
    int       m_addr = 0;
    bit       m_we = 1'b0;
    int       m_wd = 0;
    int       m_mem [N];
    int       m_rd = 0;
    bit       m_done = 1'b0;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_phase = 0; m_rd = 0; m_done = 1'b0;
            for (int i = 0; i < N; i++) m_mem[i] = 0;
        end else begin
            m_done = (m_phase == 3);
            case (m_phase)
                0: if (req_valid) begin
                       m_addr = int'(req_addr); m_we = req_we; m_wd = int'(req_wdata);
                       m_phase = 1;
                   end
                1: m_phase = 2;
                2: begin
                       if (m_we) m_mem[m_addr] = m_wd;
                       else      m_rd = m_mem[m_addr];
                       m_phase = 3;
                   end
                default: m_phase = 0;
            endcase
        end
    end

    task automatic check(string tag, int act, int exp);
        vectors++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    // per-cycle comparison, half a cycle after the outputs move
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            int exp_bus;
            exp_bus = (m_phase == 1 || m_phase == 3) ? (m_addr / COLS) :
                      (m_phase == 2) ? (m_addr % COLS) : 0;
            check("R3 busy", int'(busy), int'(m_phase != 0));
            check("R4 row_strobe", int'(row_strobe), int'(m_phase == 1));
            check("R5 col_strobe", int'(col_strobe), int'(m_phase == 2));
            check("R6 done", int'(done), int'(m_done));
            check("R2/R11 mem_addr", int'(mem_addr), exp_bus);
            check("R7 rd_data", int'(rd_data), m_rd);
        end
    end

    // one access; noise drives a foreign write while busy
    task automatic access(int a, bit we, int wd, bit noise, int exp_rd, string tag);
        @(negedge clk);
        req_valid = 1'b1; req_addr = AW'(a); req_we = we; req_wdata = W'(wd);
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            req_valid = noise; req_we = 1'b1;
            req_addr = AW'(a ^ 1); req_wdata = 8'hFF;
        end
        @(negedge clk);
        req_valid = 1'b0; req_we = 1'b0;
        if (!we) check(tag, int'(rd_data), exp_rd);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000 && !finished) begin
            finished = 1'b1;
            fails++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 busy", int'(busy), 0);
        check("R1 done", int'(done), 0);
        check("R1 rd_data", int'(rd_data), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R11 idle bus", int'(mem_addr), 0);
        access(5, 1'b0, 0, 1'b0, 0, "R1 zero cell");

        // R2: address 9 = row 2, col 1
        access(9, 1'b1, 8'hA5, 1'b0, 0, "");
        access(9, 1'b0, 0, 1'b0, 8'hA5, "R2 read 9");
        // R8: neighbours in row 2 untouched
        access(8, 1'b0, 0, 1'b0, 0, "R8 neighbour 8");
        access(11, 1'b0, 0, 1'b0, 0, "R8 neighbour 11");
        access(10, 1'b1, 8'h3C, 1'b0, 0, "");
        access(9, 1'b0, 0, 1'b0, 8'hA5, "R8 kept 9");
        access(10, 1'b0, 0, 1'b0, 8'h3C, "R8 read 10");
        // R9: repeated reads survive the destructive sense
        access(9, 1'b0, 0, 1'b0, 8'hA5, "R9 reread 1");
        access(9, 1'b0, 0, 1'b0, 8'hA5, "R9 reread 2");
        // R10: noise write to address 2 while busy must be ignored
        access(3, 1'b1, 8'h11, 1'b1, 0, "");
        access(2, 1'b0, 0, 1'b0, 0, "R10 ignored write");
        access(3, 1'b0, 0, 1'b0, 8'h11, "R10 own write");

        // R12: back-to-back, request held through the done cycle
        @(negedge clk);
        req_valid = 1'b1; req_we = 1'b1; req_addr = 4'd15; req_wdata = 8'h77;
        repeat (4) @(negedge clk);
        check("R12 accepted in done cycle", int'(done), 1);
        req_we = 1'b0; req_addr = 4'd15;
        repeat (4) @(negedge clk);
        req_valid = 1'b0;
        check("R12 chained read", int'(rd_data), 8'h77);
        repeat (4) @(negedge clk);

        // full sweep
        for (int a = 0; a < N; a++) access(a, 1'b1, (a * 7 + 3) & 8'hFF, 1'b0, 0, "");
        for (int a = 0; a < N; a++) access(a, 1'b0, 0, 1'b0, (a * 7 + 3) & 8'hFF, "R8 sweep");

        repeat (3) @(negedge clk);
        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule